// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external 32K x 8 asynchronous static RAM. The host offers one word at a time through a request/ready handshake, with a write flag, a 15-bit address and write data, and it receives read data together with a one-cycle done pulse. On the memory side the block drives the address bus and three active-low strobes: device select, write strobe and read-output enable. The 8-bit data bus is split into an outgoing word, an incoming word and a driver-enable line, so a pad ring can build the bidirectional pins around it.

Every phase length is worked out at elaboration time from the nanosecond limits of the chosen speed grade and from the clock period. The same RTL therefore serves the 35, 55 and 70 ns parts at any clock rate. The sequencer keeps the address frozen during each write strobe. It holds the read-output enable high across the whole write cycle and turns its own drivers on only after the memory's outputs have had a full cycle to release the bus. An optional standby input parks the memory deselected, and the memory is kept deselected for one read-cycle time before any access that follows standby or reset.

The state machine has seven states. WAKE holds the memory deselected for the read-cycle time and then goes to IDLE. IDLE accepts a request and moves to WR_SETUP for a write or RD_ACCESS for a read; with no request and standby asserted it moves to HOLD. HOLD returns to WAKE when standby drops. WR_SETUP lasts one cycle and moves to WR_PULSE, which moves to WR_RECOV, which returns to IDLE. RD_ACCESS returns to IDLE.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and for RC_LEN = ceil(tRC / T) cycles after it is released, sram_sel_n is high and ready is low. Ready is high in the cycle after that, where T is CLK_PERIOD_NS.
- R2: The strobes never show an illegal combination. sram_wstb_n is low only while sram_sel_n is low, and sram_wstb_n and sram_rden_n are never both low. A read drives sel low, rden low and wstb high. In IDLE, WAKE and HOLD, sel is high.
- R3: A write holds sel and wstb low together for WP_LEN = ceil(max(tWP, tDW) / T) cycles, after one setup cycle. The word driven on sram_dout is stable for the whole strobe, and the memory afterwards holds that word. Done rises max(ceil(tWC / T), WP_LEN + 2) + 1 cycles after the cycle in which the request was accepted.
- R4: sram_addr takes the host address only when a request is accepted. It never changes while sram_wstb_n is low.
- R5: sram_drive is high only during the write strobe and the cycle after it, and never while sram_rden_n is low. It rises only after sram_rden_n has been high in the previous cycle.
- R6: A read holds sel and rden low with an unchanged address for RD_LEN = max(ceil(tRC / T), ceil(tAA / T)) cycles. It registers sram_din into rdata on the last of those cycles. Done rises RD_LEN + 1 cycles after the acceptance cycle, and rdata holds its value until the next read.
- R7: Ready falls in the cycle after a request is accepted and stays low until done pulses. Done lasts exactly one cycle. A request, address or data presented while ready is low has no effect on the memory.
- R8: Two successive falls of sram_sel_n are separated by at least the write-cycle time after a write and by at least the read-cycle time after a read.
- R9: With STANDBY_EN set, standby asserted in IDLE with no pending request moves the sequencer to HOLD. In HOLD, sel stays high, ready stays low and requests are ignored. A request in IDLE takes priority over standby.
- R10: When standby drops, sel stays high and ready stays low for RC_LEN cycles, and then ready rises.
- R11: The speed-grade limits are these. Grade 0 has tWC = tRC = tAA = 35, tWP = 25 and tDW = 20. Grade 1 has 55, 45 and 25. Grade 2 has 70, 55 and 30. All values are in ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| ready | output | 1 | Sequencer can accept a request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Host word address |
| wdata | input | DATA_W | Host write word |
| rdata | output | DATA_W | Last word read |
| done | output | 1 | One-cycle completion pulse |
| standby | input | 1 | Request to park the memory deselected |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_sel_n | output | 1 | Memory select, active low |
| sram_wstb_n | output | 1 | Memory write strobe, active low |
| sram_rden_n | output | 1 | Memory read-output enable, active low |
| sram_dout | output | DATA_W | Word to drive onto the memory data pins |
| sram_din | input | DATA_W | Word sampled from the memory data pins |
| sram_drive | output | 1 | Enable for the data pin drivers |

## Verification
The bench attaches a cycle-sampled model of the memory. The model returns a poison value until the read strobes have been held for the access time, so a read phase one cycle too short brings back the wrong word. A write strobe one cycle too short, or data settling too late, is reported by the model and leaves stale data for the read-back. An address that moves under the strobe, drivers that turn on while the memory still drives the bus, and select falls spaced below the cycle time are all flagged at the pins. Requests held high through a busy write and through standby are followed by reads of the addresses they named; a sequencer that did not ignore them would show the stray data there. The ready-low stretches after reset and after standby are counted exactly, so a shortened wake period is caught.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_HOLD,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS
    } asram_state_e;

    // Write / read cycle time in ns per grade (R11).
    function automatic int grade_cycle_ns(input int grade);
        case (grade)
            0:       return 35;
            1:       return 55;
            default: return 70;
        endcase
    endfunction

    // Address-to-data access time in ns per grade.
    function automatic int grade_access_ns(input int grade);
        case (grade)
            0:       return 35;
            1:       return 55;
            default: return 70;
        endcase
    endfunction

    // Minimum write strobe width in ns per grade.
    function automatic int grade_wpulse_ns(input int grade);
        case (grade)
            0:       return 25;
            1:       return 45;
            default: return 55;
        endcase
    endfunction

    // Data-valid-before-strobe-end in ns per grade.
    function automatic int grade_dsetup_ns(input int grade);
        case (grade)
            0:       return 20;
            1:       return 25;
            default: return 30;
        endcase
    endfunction

    // Ceiling of ns / period, never less than one cycle.
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W   = 4,
    parameter int RST_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // A phase of N cycles is loaded with N-1 and ends when the count is zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int WP_LEN     = 3,
    parameter int WREC_LEN   = 1,
    parameter int RD_LEN     = 4,
    parameter int RC_LEN     = 4,
    parameter bit STANDBY_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic             standby,
    input  logic             last,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture,
    output logic             finish,
    output logic             ready,
    output logic             sel_n,
    output logic             wstb_n,
    output logic             rden_n,
    output logic             drive
);

    asram_state_e state_q;
    asram_state_e state_d;
    logic         standby_eff;

    generate
        if (STANDBY_EN) begin : g_standby
            assign standby_eff = standby;
        end else begin : g_no_standby
            assign standby_eff = 1'b0;
        end
    endgenerate

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and phase loads.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_WAKE: begin
                if (last) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (wr) begin
                        state_d  = ST_WR_SETUP;
                        load_val = CNT_W'(1);
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        load_val = CNT_W'(RD_LEN);
                    end
                end else if (standby_eff) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!standby_eff) begin
                    state_d  = ST_WAKE;
                    load     = 1'b1;
                    load_val = CNT_W'(RC_LEN);
                end
            end
            ST_WR_SETUP: begin
                if (last) begin
                    state_d  = ST_WR_PULSE;
                    load     = 1'b1;
                    load_val = CNT_W'(WP_LEN);
                end
            end
            ST_WR_PULSE: begin
                if (last) begin
                    state_d  = ST_WR_RECOV;
                    load     = 1'b1;
                    load_val = CNT_W'(WREC_LEN);
                end
            end
            ST_WR_RECOV: begin
                if (last) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_RD_ACCESS: begin
                if (last) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                    finish  = 1'b1;
                end
            end
            default: begin
                state_d = ST_WAKE;
                load     = 1'b1;
                load_val = CNT_W'(RC_LEN);
            end
        endcase
    end

    // Strobes and handshake decoded from the state.
    always_comb begin
        ready  = 1'b0;
        sel_n  = 1'b1;
        wstb_n = 1'b1;
        rden_n = 1'b1;
        drive  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
            end
            ST_WR_SETUP: begin
                sel_n = 1'b0;
            end
            ST_WR_PULSE: begin
                sel_n  = 1'b0;
                wstb_n = 1'b0;
                drive  = 1'b1;
            end
            ST_WR_RECOV: begin
                sel_n = 1'b0;
                drive = 1'b1;
            end
            ST_RD_ACCESS: begin
                sel_n  = 1'b0;
                rden_n = 1'b0;
            end
            default: begin
                sel_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              finish,
    input  logic              drive,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sram_din,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dout,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;

    // Address and data are taken only at acceptance and held to the next one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (capture) begin
                rdata_q <= sram_din;
            end
        end
    end

    assign sram_addr = addr_q;
    assign sram_dout = drive ? wdata_q : '0;
    assign rdata     = rdata_q;
    assign done      = done_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int SPEED_GRADE   = 0,
    parameter int CLK_PERIOD_NS = 10,
    parameter bit STANDBY_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    output logic              ready,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    input  logic              standby,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_sel_n,
    output logic              sram_wstb_n,
    output logic              sram_rden_n,
    output logic [DATA_W-1:0] sram_dout,
    input  logic [DATA_W-1:0] sram_din,
    output logic              sram_drive
);

    localparam int WC_LEN   = ns_to_cycles(grade_cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int RC_LEN   = ns_to_cycles(grade_cycle_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int AA_LEN   = ns_to_cycles(grade_access_ns(SPEED_GRADE), CLK_PERIOD_NS);
    localparam int WP_LEN   = ns_to_cycles(max2(grade_wpulse_ns(SPEED_GRADE),
                                                grade_dsetup_ns(SPEED_GRADE)), CLK_PERIOD_NS);
    localparam int RD_LEN   = max2(RC_LEN, AA_LEN);
    localparam int WREC_LEN = max2(1, WC_LEN - 1 - WP_LEN);
    localparam int MAX_LEN  = max2(max2(RD_LEN, RC_LEN), max2(WP_LEN, WREC_LEN));
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             last;
    logic             accept;
    logic             capture;
    logic             finish;

    asram_phase_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (RC_LEN)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    asram_seq #(
        .CNT_W      (CNT_W),
        .WP_LEN     (WP_LEN),
        .WREC_LEN   (WREC_LEN),
        .RD_LEN     (RD_LEN),
        .RC_LEN     (RC_LEN),
        .STANDBY_EN (STANDBY_EN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .wr       (wr),
        .standby  (standby),
        .last     (last),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .capture  (capture),
        .finish   (finish),
        .ready    (ready),
        .sel_n    (sram_sel_n),
        .wstb_n   (sram_wstb_n),
        .rden_n   (sram_rden_n),
        .drive    (sram_drive)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .finish    (finish),
        .drive     (sram_drive),
        .addr      (addr),
        .wdata     (wdata),
        .sram_din  (sram_din),
        .sram_addr (sram_addr),
        .sram_dout (sram_dout),
        .rdata     (rdata),
        .done      (done)
    );

endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_sel_n,
    input logic              sram_wstb_n,
    input logic              sram_rden_n,
    input logic              sram_drive
);

    assert_wstb_needs_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_wstb_n |-> !sram_sel_n);

    assert_no_strobe_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_wstb_n && !sram_rden_n));

    assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_wstb_n && !$past(sram_wstb_n)) |-> $stable(sram_addr));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_drive |-> sram_rden_n);

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_drive) |-> $past(sram_rden_n));

    assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> sram_sel_n);

endmodule

bind asram_ctrl asram_ctrl_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .ready       (ready),
    .done        (done),
    .sram_addr   (sram_addr),
    .sram_sel_n  (sram_sel_n),
    .sram_wstb_n (sram_wstb_n),
    .sram_rden_n (sram_rden_n),
    .sram_drive  (sram_drive)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int GRADE      = 1;
    // Grade 1 limits, from R11.
    localparam int T_WC = 55;
    localparam int T_RC = 55;
    localparam int T_AA = 55;
    localparam int T_WP = 45;
    localparam int T_DW = 25;
    localparam int WC_C   = (T_WC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RC_C   = (T_RC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int AA_C   = (T_AA + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WP_C   = ((T_WP > T_DW ? T_WP : T_DW) + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int WR_LAT = ((WC_C > WP_C + 2) ? WC_C : WP_C + 2) + 1;
    localparam int RD_LEN = (RC_C > AA_C) ? RC_C : AA_C;
    localparam int RD_LAT = RD_LEN + 1;
    localparam int WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        standby = 1'b0;
    logic        ready;
    logic [7:0]  rdata;
    logic        done;
    logic [14:0] sram_addr;
    logic        sram_sel_n;
    logic        sram_wstb_n;
    logic        sram_rden_n;
    logic [7:0]  sram_dout;
    logic [7:0]  sram_din;
    logic        sram_drive;

    asram_ctrl #(
        .SPEED_GRADE   (GRADE),
        .CLK_PERIOD_NS (CLK_PERIOD)
    ) u_asram_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .ready       (ready),
        .wr          (wr),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .done        (done),
        .standby     (standby),
        .sram_addr   (sram_addr),
        .sram_sel_n  (sram_sel_n),
        .sram_wstb_n (sram_wstb_n),
        .sram_rden_n (sram_rden_n),
        .sram_dout   (sram_dout),
        .sram_din    (sram_din),
        .sram_drive  (sram_drive)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT) begin
            check(1'b0, "WATCHDOG", "run did not finish", cyc, WD_LIMIT);
            summary();
        end
    end

    // ---------------- behavioural memory model ----------------
    logic [7:0] mdl_mem [int];
    logic [7:0] mdl_out = 8'hEE;
    assign sram_din = mdl_out;

    bit         p_wact = 0, p_ract = 0, p_drive = 0, p_rden_n = 1, p_sel_n = 1;
    bit         cur_wr = 0, have_prev = 0, prev_wr = 0;
    logic [14:0] p_addr = '0;
    logic [7:0]  p_dout = '0, w_last = '0;
    int         wcnt = 0, dcnt = 0, rcnt = 0, gap = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            bit wact, ract;
            wact = !sram_sel_n && !sram_wstb_n;
            ract = !sram_sel_n && !sram_rden_n && sram_wstb_n;
            if (!sram_wstb_n && sram_sel_n)
                check(1'b0, "R2", "write strobe without select", 0, 1);
            if (!sram_wstb_n && !sram_rden_n)
                check(1'b0, "R2", "write and read strobes overlap", 0, 1);
            if (sram_drive && !sram_rden_n)
                check(1'b0, "R5", "bus contention", 1, 0);
            if (sram_drive && !p_drive && !p_rden_n)
                check(1'b0, "R5", "drivers on without turnaround", 1, 0);
            if (wact && p_wact && sram_addr != p_addr)
                check(1'b0, "R4", "address moved under write strobe", int'(sram_addr), int'(p_addr));
            if (wact) begin
                cur_wr = 1;
                wcnt++;
                if (sram_drive && p_wact && p_drive && sram_dout == p_dout) dcnt++;
                else if (sram_drive) dcnt = 1;
                else dcnt = 0;
                w_last = sram_dout;
            end
            if (!wact && p_wact) begin
                if (wcnt * CLK_PERIOD < T_WP)
                    check(1'b0, "R3", "write strobe too short (ns)", wcnt * CLK_PERIOD, T_WP);
                if (dcnt * CLK_PERIOD < T_DW)
                    check(1'b0, "R3", "write data setup too short (ns)", dcnt * CLK_PERIOD, T_DW);
                mdl_mem[int'(p_addr)] = w_last;
                wcnt = 0;
            end
            if (ract) rcnt = (p_ract && sram_addr == p_addr) ? rcnt + 1 : 1;
            else rcnt = 0;
            if (ract && rcnt * CLK_PERIOD >= T_AA)
                mdl_out = mdl_mem.exists(int'(sram_addr)) ? mdl_mem[int'(sram_addr)] : 8'h00;
            else
                mdl_out = 8'hEE;
            gap++;
            if (!sram_sel_n && p_sel_n) begin
                if (have_prev && gap * CLK_PERIOD < (prev_wr ? T_WC : T_RC))
                    check(1'b0, "R8", "select falls too close (ns)", gap * CLK_PERIOD,
                          prev_wr ? T_WC : T_RC);
                have_prev = 1;
                gap = 0;
                cur_wr = wact;
            end
            if (sram_sel_n && !p_sel_n) prev_wr = cur_wr;
            p_wact = wact; p_ract = ract; p_drive = sram_drive;
            p_rden_n = sram_rden_n; p_sel_n = sram_sel_n;
            p_addr = sram_addr; p_dout = sram_dout;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         is_rd;
        logic [7:0] data;
        int         start;
        int         lat;
    } item_t;

    item_t      sb_q[$];
    logic [7:0] shadow [int];

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "done without a request", 1, 0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(cyc - it.start == it.lat, it.is_rd ? "R6" : "R3",
                      "accept-to-done cycles", cyc - it.start, it.lat);
                if (it.is_rd)
                    check(rdata == it.data, "R6", "read data", int'(rdata), int'(it.data));
            end
        end
    end

    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d;
        it.is_rd = !w;
        it.data  = (!w && shadow.exists(int'(a))) ? shadow[int'(a)] : 8'h00;
        it.start = cyc;
        it.lat   = w ? WR_LAT : RD_LAT;
        sb_q.push_back(it);
        if (w) shadow[int'(a)] = d;
        @(negedge clk);
        req = 1'b0;
        check(ready == 1'b0, "R7", "ready low after accept", int'(ready), 0);
    endtask

    task automatic wait_drained();
        @(negedge clk);
        while (sb_q.size() != 0 || !ready) @(negedge clk);
    endtask

    task automatic count_wake(input string tag);
        int n = 0;
        @(negedge clk);
        while (!ready && n < 200) begin
            if (!sram_sel_n) check(1'b0, tag, "select low while waking", 0, 1);
            n++;
            @(negedge clk);
        end
        check(n == RC_C, tag, "ready-low cycles while waking", n, RC_C);
    endtask

    initial begin
        // R1: reset state and wake period.
        repeat (3) @(negedge clk);
        check(sram_sel_n == 1'b1, "R1", "select in reset", int'(sram_sel_n), 1);
        check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        count_wake("R1");

        // R3/R6: basic patterns, boundary addresses, back-to-back (R8).
        issue(1, 15'h0000, 8'hA5);
        issue(1, 15'h7FFF, 8'h5A);
        issue(1, 15'h1234, 8'hFF);
        issue(1, 15'h0001, 8'h00);
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);
        issue(0, 15'h0001, 8'h00);
        issue(0, 15'h0042, 8'h00);
        issue(1, 15'h1234, 8'h3C);
        issue(0, 15'h1234, 8'h00);
        wait_drained();
        check(rdata == 8'h3C, "R6", "rdata held after read", int'(rdata), 8'h3C);

        // R7: request held while busy has no effect.
        issue(1, 15'h0100, 8'h81);
        req = 1'b1; wr = 1'b1; addr = 15'h0200; wdata = 8'h99;
        repeat (WR_LAT - 3) @(negedge clk);
        req = 1'b0;
        wait_drained();
        issue(0, 15'h0200, 8'h00);
        issue(0, 15'h0100, 8'h00);
        wait_drained();

        // R9: standby parks the memory; requests are ignored in hold.
        @(negedge clk);
        standby = 1'b1;
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R9", "ready in standby", int'(ready), 0);
        check(sram_sel_n == 1'b1, "R9", "select in standby", int'(sram_sel_n), 1);
        req = 1'b1; wr = 1'b1; addr = 15'h0300; wdata = 8'h77;
        repeat (4) @(negedge clk);
        check(ready == 1'b0, "R9", "ready with request in standby", int'(ready), 0);
        req = 1'b0;
        @(negedge clk);
        // R10: wake period after standby.
        standby = 1'b0;
        count_wake("R10");
        issue(0, 15'h0300, 8'h00);
        wait_drained();

        // R9: a request beats standby in IDLE.
        @(negedge clk);
        standby = 1'b1; req = 1'b1; wr = 1'b1; addr = 15'h0400; wdata = 8'h42;
        sb_q.push_back('{is_rd: 1'b0, data: 8'h00, start: cyc, lat: WR_LAT});
        shadow[int'(15'h0400)] = 8'h42;
        @(negedge clk);
        req = 1'b0; standby = 1'b0;
        check(ready == 1'b0, "R9", "request accepted over standby", int'(ready), 0);
        wait_drained();
        issue(0, 15'h0400, 8'h00);
        wait_drained();

        repeat (4) @(negedge clk);
        summary();
    end

endmodule